// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM and takes the memory from a cold start to a programmed, ready state. From reset it holds the clock-enable line low and counts clock cycles for as long as the supply-stable input stays high. Once the required stable interval has passed, it raises clock-enable and walks the command bus through a fixed order of steps: bank precharge, DLL enable, DLL reset, a counted DLL lock period, two auto-refresh cycles and the final mode-register write. Every command is followed by a timed run of NOP cycles.

The final mode-register write carries the burst length, the burst type and the CAS latency taken from the configuration inputs. A configuration bit places that write either before or after the refresh pair. A parameter chooses between one precharge to all banks and one precharge per bank in ascending order. When the sequence ends, `init_done` rises and stays high. From then on the block drives only NOP with clock-enable high, so that a normal controller can take over the bus.

There is no data stream, so there is no valid/ready handshake. All pins are plain control and status lines. The configuration inputs must stay stable from reset release until `init_done` is high.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While `cke` is low the command bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 0111, `ba` and `addr` zero). `cke` stays low until `pwr_ok` has been sampled high on STABLE_CYC consecutive rising edges. A low sample restarts the count.
- R2: The cycle after the stable count completes shows NOP with `cke` high. After that, `cke` never falls again before reset.
- R3: With PER_BANK_PRE = 0, the next cycle issues one precharge (0010) with `addr[10]` high and `ba` = 0.
- R4: With PER_BANK_PRE = 1, the block instead issues one precharge per bank with `addr[10]` low and `ba` = 0, 1, … NUM_BANKS-1 in turn. Each precharge has its own T_RP gap.
- R5: After precharge, the extended mode write (0000) is issued with `ba` = 1 and `addr` all zero. Bit 0 low enables the DLL.
- R6: Next comes a mode write with `ba` = 0 and `addr[8]` high (DLL reset). `addr[2:0]` is the burst length, `addr[3]` the burst type, `addr[6:4]` the CAS latency, and `addr[7]` and all bits above 8 are zero.
- R7: The final mode write has the same fields with `addr[8]` low. It comes at least one NOP cycle after the preceding gap, and no sooner than T_LOCK cycles after the DLL-reset write, whichever is later.
- R8: Exactly two auto-refresh commands (0001) are issued.
- R9: With `cfg_mrs_first` high, the final mode write comes before the two refreshes. With it low, the write comes after them.
- R10: Each precharge is followed by T_RP NOP cycles, each mode write by T_MRD NOP cycles, and each refresh by T_RFC NOP cycles. No two commands are adjacent.
- R11: No mode write of either kind occurs before every bank has been precharged.
- R12: `init_done` rises in the cycle after the last gap ends and holds until reset. While it is high, the bus shows NOP with `cke` high.
- R13: While `rst_n` is low, `cke` is low, the bus shows NOP, `ba` and `addr` are zero and `init_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the memory clock reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | High while supplies and clock are within range |
| cfg_burst_len | input | 3 | Burst-length code for the mode word |
| cfg_burst_seq | input | 1 | Burst-type bit for the mode word |
| cfg_cas_lat | input | 3 | CAS-latency code for the mode word |
| cfg_mrs_first | input | 1 | 1: final mode write before refreshes |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once initialization has finished |

## Verification
The bound checker watches a set of rules on every cycle:
- NOP while `cke` is low, and `cke` never falling once it is high.
- A NOP after every command.
- No mode write before all banks are precharged.
- No test-mode bit in a mode word.
- The lock distance before the final mode write.
- The sticky done flag, which is only allowed after both refreshes and the final write.

Other properties can only be shown by the bench's scenarios: the exact gap lengths, the order of steps for each setting of `cfg_mrs_first` and PER_BANK_PRE, the restart of the stable count after a supply glitch, and the field values in each mode word.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] bus_cmd_t;
  localparam bus_cmd_t CMD_NOP  = 4'b0111;
  localparam bus_cmd_t CMD_PRE  = 4'b0010;
  localparam bus_cmd_t CMD_REF  = 4'b0001;
  localparam bus_cmd_t CMD_MODE = 4'b0000;

  localparam int A_ALLBANK = 10;

  typedef enum logic [3:0] {
    ST_STABLE, ST_CKE, ST_PRE, ST_EMRS, ST_MRS_DLLRST,
    ST_REF, ST_LOCKWAIT, ST_MRS_FINAL, ST_GAP, ST_DONE
  } seq_state_t;

  // mode word: [8] DLL reset, [7] test (always 0), [6:4] CAS, [3] type, [2:0] length
  function automatic logic [8:0] mode_word(input logic [2:0] bl, input logic bt,
                                           input logic [2:0] cl, input logic dll_rst);
    return {dll_rst, 1'b0, cl, bt, bl};
  endfunction
endpackage

// File: rtl/ddr_pwrup_stable.sv
module ddr_pwrup_stable #(
  parameter int unsigned CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwr_ok,
  output logic ripe
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign ripe = en && pwr_ok && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!en || !pwr_ok)  cnt <= '0;
    else if (!ripe)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ddr_pwrup_gap.sv
module ddr_pwrup_gap #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (load)         left <= len - 1'b1;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign expired = (left == '0);
endmodule

// File: rtl/ddr_pwrup_lock.sv
module ddr_pwrup_lock #(
  parameter int unsigned LOCK = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int unsigned LW = $clog2(LOCK + 1);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (start)                            cnt <= LW'(1);
    else if (cnt != '0 && cnt < LW'(LOCK))     cnt <= cnt + 1'b1;
  end

  // next cycle is at least LOCK cycles past the start command
  assign ready = (cnt >= LW'(LOCK - 1));
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter int unsigned STABLE_CYC   = 25000,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned T_RFC        = 10,
  parameter int unsigned T_LOCK       = 200,
  parameter bit          PER_BANK_PRE = 1'b0,
  parameter int unsigned NUM_BANKS    = 4,
  parameter int unsigned BA_W         = 2,
  parameter int unsigned ADDR_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_seq,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_mrs_first,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int unsigned G1   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int unsigned GMAX = (G1 > T_RFC) ? G1 : T_RFC;
  localparam int unsigned GW   = $clog2(GMAX + 1);

  seq_state_t state, nxt, after_q, nxt_after;
  logic       ripe, gap_over, gap_load, lock_ready, ref_seen;
  logic [GW-1:0] gap_len;
  logic [BA_W-1:0] pre_ba;
  logic       pre_a10, pre_last;
  bus_cmd_t   cmd;

  ddr_pwrup_stable #(.CYCLES(STABLE_CYC)) u_stable (
    .clk(clk), .rst_n(rst_n), .en(state == ST_STABLE), .pwr_ok(pwr_ok), .ripe(ripe));

  ddr_pwrup_gap #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .len(gap_len), .expired(gap_over));

  ddr_pwrup_lock #(.LOCK(T_LOCK)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(state == ST_MRS_DLLRST), .ready(lock_ready));

  generate
    if (PER_BANK_PRE) begin : g_per_bank
      logic [BA_W-1:0] bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bank_q <= '0;
        else if (state == ST_PRE)  bank_q <= bank_q + 1'b1;
      end
      assign pre_ba   = bank_q;
      assign pre_a10  = 1'b0;
      assign pre_last = (bank_q == BA_W'(NUM_BANKS - 1));
    end else begin : g_all_bank
      assign pre_ba   = '0;
      assign pre_a10  = 1'b1;
      assign pre_last = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt       = state;
    nxt_after = after_q;
    gap_load  = 1'b0;
    gap_len   = GW'(T_MRD);
    case (state)
      ST_STABLE:     if (ripe) nxt = ST_CKE;
      ST_CKE:        nxt = ST_PRE;
      ST_PRE: begin
        gap_load = 1'b1; gap_len = GW'(T_RP); nxt = ST_GAP;
        nxt_after = pre_last ? ST_EMRS : ST_PRE;
      end
      ST_EMRS: begin
        gap_load = 1'b1; nxt = ST_GAP; nxt_after = ST_MRS_DLLRST;
      end
      ST_MRS_DLLRST: begin
        gap_load = 1'b1; nxt = ST_GAP;
        nxt_after = cfg_mrs_first ? ST_LOCKWAIT : ST_REF;
      end
      ST_REF: begin
        gap_load = 1'b1; gap_len = GW'(T_RFC); nxt = ST_GAP;
        if (!ref_seen)          nxt_after = ST_REF;
        else if (cfg_mrs_first) nxt_after = ST_DONE;
        else                    nxt_after = ST_LOCKWAIT;
      end
      ST_LOCKWAIT:   if (lock_ready) nxt = ST_MRS_FINAL;
      ST_MRS_FINAL: begin
        gap_load = 1'b1; nxt = ST_GAP;
        nxt_after = cfg_mrs_first ? ST_REF : ST_DONE;
      end
      ST_GAP:        if (gap_over) nxt = after_q;
      ST_DONE:       nxt = ST_DONE;
      default:       nxt = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_STABLE;
      after_q  <= ST_STABLE;
      ref_seen <= 1'b0;
    end else begin
      state   <= nxt;
      after_q <= nxt_after;
      if (state == ST_REF) ref_seen <= 1'b1;
    end
  end

  always_comb begin
    cke  = (state != ST_STABLE);
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (state)
      ST_PRE: begin
        cmd = CMD_PRE; ba = pre_ba; addr[A_ALLBANK] = pre_a10;
      end
      ST_EMRS: begin
        cmd = CMD_MODE; ba = BA_W'(1);
      end
      ST_MRS_DLLRST: begin
        cmd = CMD_MODE;
        addr[8:0] = mode_word(cfg_burst_len, cfg_burst_seq, cfg_cas_lat, 1'b1);
      end
      ST_MRS_FINAL: begin
        cmd = CMD_MODE;
        addr[8:0] = mode_word(cfg_burst_len, cfg_burst_seq, cfg_cas_lat, 1'b0);
      end
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign init_done = (state == ST_DONE);
endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter int unsigned T_LOCK    = 200,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ADDR_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  localparam int unsigned LW = $clog2(T_LOCK + 1);
  logic [3:0] c;
  logic is_nop, is_pre, is_mode, is_ref, dll_rst, final_mrs;
  logic [NUM_BANKS-1:0] pre_mask;
  logic [LW-1:0] lk;
  logic [1:0] refs;
  logic final_seen;

  assign c         = {cs_n, ras_n, cas_n, we_n};
  assign is_nop    = (c == 4'b0111);
  assign is_pre    = (c == 4'b0010);
  assign is_ref    = (c == 4'b0001);
  assign is_mode   = (c == 4'b0000);
  assign dll_rst   = is_mode && (ba == '0) && addr[8];
  assign final_mrs = is_mode && (ba == '0) && !addr[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_mask <= '0; lk <= '0; refs <= '0; final_seen <= 1'b0;
    end else begin
      if (is_pre) pre_mask <= addr[10] ? '1 : (pre_mask | (NUM_BANKS'(1) << ba));
      if (dll_rst) lk <= LW'(1);
      else if (lk != '0 && lk < LW'(T_LOCK)) lk <= lk + 1'b1;
      if (is_ref && refs != 2'd2) refs <= refs + 1'b1;
      if (final_mrs) final_seen <= 1'b1;
    end
  end

  // R1
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> is_nop && addr == '0);
  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke);
  // R10
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) !is_nop |=> is_nop);
  // R11
  mode_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mode |-> &pre_mask);
  // R6
  no_test_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mode && ba == '0 |-> !addr[7] && addr[ADDR_W-1:9] == '0);
  // R5
  emrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mode && ba != '0 |-> addr == '0);
  // R7
  lock_dist_chk: assert property (@(posedge clk) disable iff (!rst_n) final_mrs |-> lk >= LW'(T_LOCK));
  // R12
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done);
  // R12
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cke && is_nop && refs == 2'd2 && final_seen);
endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
  .T_LOCK(T_LOCK), .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/sim_ddr_pwrup_seq.sv
`timescale 1ns/1ps
module sim_ddr_pwrup_seq;
  localparam int STB = 20, TRP = 2, TMRD = 2, TRFC = 5, TLK = 12;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REFC = 4'b0001, MODE = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0;
  logic [2:0] bl = 3'd0, cl = 3'd0;
  logic bt = 1'b0, mfirst = 1'b0;
  logic cke0, cs0, ras0, cas0, we0, done0, cke1, cs1, ras1, cas1, we1, done1;
  logic [1:0] ba0, ba1;
  logic [12:0] a0, a1;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [20:0] q0[$], q1[$];
  string t0[$], t1[$];

  always #4 clk = ~clk;

  ddr_pwrup_seq #(.STABLE_CYC(STB), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .T_LOCK(TLK),
    .PER_BANK_PRE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cfg_burst_len(bl), .cfg_burst_seq(bt),
    .cfg_cas_lat(cl), .cfg_mrs_first(mfirst), .cke(cke0), .cs_n(cs0), .ras_n(ras0),
    .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(a0), .init_done(done0));

  ddr_pwrup_seq #(.STABLE_CYC(STB), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .T_LOCK(TLK),
    .PER_BANK_PRE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cfg_burst_len(bl), .cfg_burst_seq(bt),
    .cfg_cas_lat(cl), .cfg_mrs_first(mfirst), .cke(cke1), .cs_n(cs1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(a1), .init_done(done1));

  function automatic logic [20:0] ent(input logic k, input logic [3:0] c, input logic [1:0] b,
                                      input logic [12:0] a, input logic d);
    return {k, c, b, a, d};
  endfunction

  function automatic logic [12:0] mword(input logic rst);
    return {4'b0, rst, 1'b0, cl, bt, bl};
  endfunction

  function automatic int qsize(input int sel);
    return (sel == 0) ? q0.size() : q1.size();
  endfunction

  task automatic push(input int sel, input logic [20:0] e, input string tg);
    if (sel == 0) begin q0.push_back(e); t0.push_back(tg); end
    else begin q1.push_back(e); t1.push_back(tg); end
  endtask

  task automatic gaps(input int sel, input int n);
    for (int k = 0; k < n; k++) push(sel, ent(1, NOP, 0, 0, 0), "R10");
  endtask

  task automatic lock_then_final(input int sel, input int r);
    push(sel, ent(1, NOP, 0, 0, 0), "R7");
    while (qsize(sel) < r + TLK) push(sel, ent(1, NOP, 0, 0, 0), "R7");
    push(sel, ent(1, MODE, 0, mword(1'b0), 0), mfirst ? "R9" : "R7");
    gaps(sel, TMRD);
  endtask

  task automatic refs(input int sel);
    for (int k = 0; k < 2; k++) begin push(sel, ent(1, REFC, 0, 0, 0), "R8"); gaps(sel, TRFC); end
  endtask

  task automatic build(input int sel, input bit per_bank);
    int r;
    push(sel, ent(1, NOP, 0, 0, 0), "R2");
    if (per_bank) begin
      for (int b = 0; b < 4; b++) begin push(sel, ent(1, PRE, 2'(b), 0, 0), "R4"); gaps(sel, TRP); end
    end else begin
      push(sel, ent(1, PRE, 0, 13'h400, 0), "R3"); gaps(sel, TRP);
    end
    // R11: mode writes queued only after every precharge
    push(sel, ent(1, MODE, 1, 0, 0), "R5,R11"); gaps(sel, TMRD);
    r = qsize(sel);
    push(sel, ent(1, MODE, 0, mword(1'b1), 0), "R6"); gaps(sel, TMRD);
    if (mfirst) begin lock_then_final(sel, r); refs(sel); end
    else begin refs(sel); lock_then_final(sel, r); end
  endtask

  task automatic cmp(input int sel, input logic [20:0] exp, input string tg);
    logic [20:0] got;
    got = (sel == 0) ? {cke0, cs0, ras0, cas0, we0, ba0, a0, done0}
                     : {cke1, cs1, ras1, cas1, we1, ba1, a1, done1};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s u%0d got=%h exp=%h t=%0t", tg, sel, got, exp, $time);
    end
  endtask

  task automatic run(input bit mf, input logic [2:0] l, input logic t, input logic [2:0] c,
                     input bit glitch);
    int runs, i, cyc, last;
    bit stable_ph;
    rst_n = 1'b0; pwr_ok = 1'b0;
    mfirst = mf; bl = l; bt = t; cl = c;
    q0.delete(); q1.delete(); t0.delete(); t1.delete();
    build(0, 1'b0); build(1, 1'b1);
    repeat (3) @(negedge clk);
    cmp(0, ent(0, NOP, 0, 0, 0), "R13");
    cmp(1, ent(0, NOP, 0, 0, 0), "R13");
    rst_n = 1'b1;
    stable_ph = 1; runs = 0; i = 0; cyc = 0;
    last = (q0.size() > q1.size() ? q0.size() : q1.size()) + 6;
    while (stable_ph || i < last) begin
      @(posedge clk);
      if (stable_ph) runs = pwr_ok ? runs + 1 : 0;
      @(negedge clk);
      if (stable_ph && runs >= STB) stable_ph = 0;
      if (stable_ph) begin
        cmp(0, ent(0, NOP, 0, 0, 0), "R1");
        cmp(1, ent(0, NOP, 0, 0, 0), "R1");
      end else begin
        if (i < q0.size()) cmp(0, q0[i], t0[i]); else cmp(0, ent(1, NOP, 0, 0, 1), "R12");
        if (i < q1.size()) cmp(1, q1[i], t1[i]); else cmp(1, ent(1, NOP, 0, 0, 1), "R12");
        i++;
      end
      cyc++;
      pwr_ok = glitch ? (cyc >= 2 && cyc != 11) : 1'b1;
    end
  endtask

  initial begin
    run(1'b1, 3'b010, 1'b0, 3'b010, 1'b1);
    run(1'b0, 3'b011, 1'b1, 3'b011, 1'b0);
    run(1'b1, 3'b001, 1'b1, 3'b101, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule